// File: doc/BRIEF.md
# Cascadable Sequential Configuration Memory Reader

This block is the read side of a small one-time-programmable memory that feeds a configuration loader. The memory is not addressed from outside. An internal position counter starts at zero, and each qualifying rising edge of the loader's clock moves it one item forward. An item is one byte in parallel mode, or one bit in serial mode, sent most significant bit first. The contents are a parameterized array of `DEPTH` bytes that the design computes at elaboration from a seed.

Several devices can be chained. The chip-enable output of one device drives the chip-enable input of the next, and all devices share the clock and the data lines. When a device steps one position past its last item, it releases the data bus and enables its successor. The two devices therefore form a single stream with no gap and no overlap. A combined output-enable/reset pin, whose active level is chosen by a strap, clears the position. A BUSY input freezes the stream. Tri-state is carried as a per-bit enable vector beside the data vector.

Top module: `cfg_stream_rom`

## Requirements
- R1: Data enables are non-zero only while `ce_n` is Low, the OE/reset pin is in its enable state, and the position has not gone past terminal count. In every other case `dout_en` is 0 and `dout` is 0.
- R2: A rising clock edge moves the position forward by exactly one item when the device is enabled, not past terminal count, and `busy` is Low. The first item after a clear is item 0.
- R3: While `busy` is High, clock edges leave the position unchanged, and the same item stays on the enabled pins.
- R4: With `rst_pol_hi` = 1, a High level on `oe_rst` is reset and a Low level is enable. With `rst_pol_hi` = 0, the meanings are swapped.
- R5: While reset is active, the position is held at zero and all enables are 0. After release, the stream restarts at item 0.
- R6: While `ce_n` is High, the position is cleared and all enables are 0 whatever `oe_rst` is, and `standby` = 1. `standby` equals `ce_n`.
- R7: A qualifying edge at terminal count moves the device past terminal count. From then on the position does not change, and all enables are 0.
- R8: `ce_out_n` is Low only while the device is enabled and past terminal count. It returns High as soon as OE turns inactive or `ce_n` goes High.
- R9: With `par_mode` = 0, only bit 0 is enabled (`dout_en` = 8'h01). Item k is bit (7 - k mod 8) of byte k/8. Terminal count is bit 0 of byte `DEPTH`-1.
- R10: With `par_mode` = 1, `dout_en` = 8'hFF, and item k is byte k, one byte per clock.
- R11: Byte a holds ((29*a + `SEED`) mod 256) XOR floor(a/2).
- R12: In a chain of two devices, the combined stream is the first device's items followed directly by the second device's items. The two devices never enable the same pin in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loader clock; rising edges step the position |
| ce_n | input | 1 | Chip enable, active Low |
| oe_rst | input | 1 | Combined output-enable / reset pin |
| rst_pol_hi | input | 1 | Strap: 1 = High on `oe_rst` resets, 0 = Low resets |
| busy | input | 1 | Stall: High blocks counting |
| par_mode | input | 1 | Strap: 1 = byte-wide output, 0 = bit-serial output on bit 0 |
| ce_out_n | output | 1 | Chip enable for the next device, active Low |
| dout | output | 8 | Data value (0 when not driven) |
| dout_en | output | 8 | Per-bit output enable |
| standby | output | 1 | Standby indication |

## Verification
A position counter that is wrong shows up at once as a wrong item on the enabled pins, because the output is a combinational function of the position. A count that skips, repeats or stalls on a BUSY-free edge is therefore visible in the very next cycle. A terminal-count flag that is off by one shows up at the cascade boundary in the same cycle. It appears there as a missing or doubled item, as two devices enabling the same pin, or as `ce_out_n` falling too early or too late. A clear that is lost on reset, on a polarity change or on `ce_n` leaves the next stream starting at a non-zero item, which the first compare after release catches.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
  // contents of byte a for a given seed
  function automatic logic [7:0] cell_value(int unsigned a, logic [7:0] seed);
    int unsigned mix;
    mix = (a * 29 + int'(seed)) % 256;
    return 8'(mix) ^ 8'(a >> 1);
  endfunction

  // enable pattern for the selected width
  function automatic logic [7:0] lane_mask(logic par);
    return par ? 8'hFF : 8'h01;
  endfunction
endpackage

// File: rtl/cfg_gate.sv
module cfg_gate (
  input  logic ce_n,
  input  logic oe_rst,
  input  logic rst_pol_hi,
  input  logic busy,
  input  logic past_tc,
  output logic clr,
  output logic adv,
  output logic drive,
  output logic ce_out_n,
  output logic standby
);
  logic rst_act;
  logic active;

  assign rst_act  = rst_pol_hi ? oe_rst : ~oe_rst;
  assign active   = ~ce_n & ~rst_act;
  assign clr      = ~active;
  assign adv      = active & ~past_tc & ~busy;
  assign drive    = active & ~past_tc;
  assign ce_out_n = ~(active & past_tc);
  assign standby  = ce_n;
endmodule

// File: rtl/cfg_counter.sv
module cfg_counter #(
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                adv,
  input  logic                par_mode,
  output logic [$clog2(DEPTH > 1 ? DEPTH : 2)-1:0] byte_addr,
  output logic [2:0]          bit_idx,
  output logic                past_tc
);
  localparam int AW = $clog2(DEPTH > 1 ? DEPTH : 2);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic at_tc;
  logic byte_done;

  assign byte_done = par_mode | (bit_idx == 3'd7);
  assign at_tc     = (byte_addr == LAST) & byte_done;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      byte_addr <= '0;
      bit_idx   <= '0;
      past_tc   <= 1'b0;
    end else if (adv) begin
      if (at_tc) begin
        past_tc <= 1'b1;
      end else if (byte_done) begin
        byte_addr <= byte_addr + 1'b1;
        bit_idx   <= '0;
      end else begin
        bit_idx <= bit_idx + 3'd1;
      end
    end
  end

  AST_PAST_TC_STICKY: assert property (@(posedge clk) disable iff (clr)
    past_tc |=> past_tc) else $error("past terminal count left"); // R7

  AST_HOLD_NO_ADVANCE: assert property (@(posedge clk) disable iff (clr)
    !adv |=> $stable({byte_addr, bit_idx, past_tc})) else $error("position moved without advance"); // R3

  AST_SERIAL_STEP: assert property (@(posedge clk) disable iff (clr)
    (adv && !par_mode && bit_idx != 3'd7) |=> (bit_idx == $past(bit_idx) + 3'd1)) else $error("serial bit step wrong"); // R9
endmodule

// File: rtl/cfg_array.sv
module cfg_array
  import cfg_rom_pkg::*;
#(
  parameter int          DEPTH = 8,
  parameter logic [7:0]  SEED  = 8'h5A
) (
  input  logic [$clog2(DEPTH > 1 ? DEPTH : 2)-1:0] byte_addr,
  input  logic [2:0]   bit_idx,
  input  logic         par_mode,
  input  logic         drive,
  output logic [7:0]   dout,
  output logic [7:0]   dout_en
);
  logic [7:0] cells [DEPTH];
  logic [7:0] cur;
  logic       sel_bit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign cells[g] = cell_value(g, SEED);
  end

  assign cur     = cells[byte_addr];
  assign sel_bit = cur[3'd7 - bit_idx];

  always_comb begin
    if (!drive) begin
      dout    = '0;
      dout_en = '0;
    end else begin
      dout    = par_mode ? cur : {7'b0, sel_bit};
      dout_en = lane_mask(par_mode);
    end
  end
endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom #(
  parameter int         DEPTH = 8,
  parameter logic [7:0] SEED  = 8'h5A
) (
  input  logic       clk,
  input  logic       ce_n,
  input  logic       oe_rst,
  input  logic       rst_pol_hi,
  input  logic       busy,
  input  logic       par_mode,
  output logic       ce_out_n,
  output logic [7:0] dout,
  output logic [7:0] dout_en,
  output logic       standby
);
  localparam int AW = $clog2(DEPTH > 1 ? DEPTH : 2);

  logic          clr, adv, drive, past_tc;
  logic [AW-1:0] byte_addr;
  logic [2:0]    bit_idx;

  cfg_gate u_gate (
    .ce_n(ce_n), .oe_rst(oe_rst), .rst_pol_hi(rst_pol_hi), .busy(busy),
    .past_tc(past_tc), .clr(clr), .adv(adv), .drive(drive),
    .ce_out_n(ce_out_n), .standby(standby)
  );

  cfg_counter #(.DEPTH(DEPTH)) u_count (
    .clk(clk), .clr(clr), .adv(adv), .par_mode(par_mode),
    .byte_addr(byte_addr), .bit_idx(bit_idx), .past_tc(past_tc)
  );

  cfg_array #(.DEPTH(DEPTH), .SEED(SEED)) u_array (
    .byte_addr(byte_addr), .bit_idx(bit_idx), .par_mode(par_mode),
    .drive(drive), .dout(dout), .dout_en(dout_en)
  );

  always_comb begin
    if (ce_n) begin
      AST_FLOAT_IN_STANDBY: assert (dout_en == 8'h00 && ce_out_n) else $error("driven while deselected"); // R6
    end
    if (!par_mode) begin
      AST_SERIAL_ONE_PIN: assert ((dout_en & 8'hFE) == 8'h00) else $error("serial drives upper bits"); // R9
    end
    if (!ce_out_n) begin
      AST_HANDOFF_RELEASES: assert (dout_en == 8'h00) else $error("bus driven after handoff"); // R8
    end
  end
endmodule

// File: tb/test_cfg_stream_rom.sv
`timescale 1ns/1ps
module test_cfg_stream_rom;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic chain_ce_n, oe_rst, pol_hi, busy, par;
  logic       co0, co1, sb0, sb1;
  logic [7:0] d0, d1, e0, e1;

  int checks = 0;
  int errors = 0;
  int idx    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cfg_stream_rom #(.DEPTH(DEPTH), .SEED(8'h5A)) i_cfg_stream_rom (
    .clk(clk), .ce_n(chain_ce_n), .oe_rst(oe_rst), .rst_pol_hi(pol_hi),
    .busy(busy), .par_mode(par), .ce_out_n(co0), .dout(d0),
    .dout_en(e0), .standby(sb0)
  );

  cfg_stream_rom #(.DEPTH(DEPTH), .SEED(8'hC3)) i_cfg_stream_rom_b (
    .clk(clk), .ce_n(co0), .oe_rst(oe_rst), .rst_pol_hi(pol_hi),
    .busy(busy), .par_mode(par), .ce_out_n(co1), .dout(d1),
    .dout_en(e1), .standby(sb1)
  );

  function automatic int item_ref(int dev, int k, bit p);
    int s, a, b;
    s = (dev == 0) ? 90 : 195;
    a = p ? k : k / 8;
    b = ((a * 29 + s) % 256) ^ (a / 2);
    return p ? b : ((b >> (7 - (k % 8))) & 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare the chain against the model, then clock it once
  task automatic cycle(string req);
    bit rst_act, act;
    int n, dev, item, exp_en;
    #1;
    rst_act = pol_hi ? oe_rst : !oe_rst;
    act = !chain_ce_n && !rst_act;
    if (!act) idx = 0;
    n = par ? DEPTH : DEPTH * 8;
    dev = !act ? -1 : (idx < n) ? 0 : (idx < 2 * n) ? 1 : -1;
    exp_en = (dev < 0) ? 0 : (par ? 'hFF : 'h01);
    chk(e0 == ((dev == 0) ? exp_en : 0), req, "enable dev0", e0, (dev == 0) ? exp_en : 0);
    chk(e1 == ((dev == 1) ? exp_en : 0), req, "enable dev1", e1, (dev == 1) ? exp_en : 0);
    chk((e0 & e1) == 0, "R12", "overlap", e0 & e1, 0);
    if (dev >= 0) begin
      item = item_ref(dev, idx - dev * n, par);
      if (par) chk(((dev == 0) ? d0 : d1) == item, "R11", "byte", (dev == 0) ? d0 : d1, item);
      else     chk(((dev == 0) ? d0[0] : d1[0]) == item, "R9", "bit", (dev == 0) ? d0[0] : d1[0], item);
    end
    chk(co0 == !(act && idx >= n), req, "ce_out dev0", co0, !(act && idx >= n));
    chk(co1 == !(act && idx >= 2 * n), "R8", "ce_out dev1", co1, !(act && idx >= 2 * n));
    chk(sb0 == chain_ce_n, "R6", "standby dev0", sb0, chain_ce_n);
    chk(sb1 == co0, "R6", "standby dev1", sb1, co0);
    @(posedge clk);
    if (act && !busy && idx < 2 * n) idx++;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pol_hi = 0; oe_rst = 0; chain_ce_n = 0; busy = 0; par = 1;
    @(negedge clk);
    cycle("R5"); cycle("R5");
    chain_ce_n = 1; oe_rst = 1; cycle("R6"); cycle("R1");
    chain_ce_n = 0;
    // parallel stream across the cascade with BUSY stalls
    for (int i = 0; i < 2 * DEPTH * 3 / 2 + 6; i++) begin
      busy = (i % 3 == 2);
      cycle(busy ? "R3" : "R10");
    end
    busy = 0;
    for (int i = 0; i < 3; i++) cycle("R7");
    oe_rst = 0; cycle("R8"); cycle("R1");
    oe_rst = 1;
    // mid-stream reset restarts at item 0
    for (int i = 0; i < 5; i++) cycle("R2");
    oe_rst = 0; cycle("R5");
    oe_rst = 1;
    for (int i = 0; i < 11; i++) cycle("R2");
    // CE High mid-stream clears and idles
    chain_ce_n = 1; cycle("R6"); cycle("R6");
    chain_ce_n = 0;
    for (int i = 0; i < 3; i++) cycle("R2");
    // serial mode through both devices
    oe_rst = 0; cycle("R5");
    par = 0; oe_rst = 1;
    for (int i = 0; i < 2 * DEPTH * 8 + 20; i++) begin
      busy = (i % 7 == 3);
      cycle(busy ? "R3" : "R9");
    end
    busy = 0;
    for (int i = 0; i < 2; i++) cycle("R7");
    // active-High reset polarity
    par = 1; pol_hi = 1; oe_rst = 1; cycle("R4"); cycle("R4");
    oe_rst = 0;
    for (int i = 0; i < 2 * DEPTH + 3; i++) cycle("R4");
    oe_rst = 1; cycle("R4");
    oe_rst = 0;
    for (int i = 0; i < 3; i++) cycle("R12");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule